// File: doc/BRIEF.md
# Receive descriptor completion decoder

This block takes the two raw status words that a receive DMA engine has written back into a descriptor and decides whether the host can use that descriptor yet. If it can, the block unpacks the words into a normalized receive result: frame length, received signal strength, raw rate code, antenna, more-fragments flag, key index and one error class. An error class of PHY error also carries an error code.

A descriptor whose done bit is clear is reported as pending. A descriptor whose done bit is set is also reported as pending in one case: the following descriptor is not yet done, and the hardware receive pointer still holds this descriptor's address. In that case the descriptor may be the self-linked tail of the ring, and the engine could fill it again.

Requests enter through a valid/ready handshake. Each accepted request produces one registered response, one cycle later. That response is held until the consumer takes it.

Top module: `rx_status_decoder`

## Requirements
- R1: When bit 0 (done) of status word 1 is clear, the response has pend_o = 1 and every result field is zero.
- R2: When done is set, next_done_i = 0 and hw_ptr_i equals desc_addr_i, the response is pending as in R1. If next_done_i = 1 or the two addresses differ, a decoded result is given (pend_o = 0).
- R3: When bit 1 (frame OK) of status word 1 is clear, err_o takes exactly one class, chosen in this priority order: CRC (bit 2, code 1), then decrypt CRC (bit 3, code 2), then FIFO overrun (bit 4, code 3). If none of those bits is set, the class is PHY (code 4).
- R4: For a PHY class, phy_o carries bits [7:5] of status word 1. For every other class, phy_o is zero.
- R5: When bit 8 (key valid) of status word 1 is set, key_o = {1'b0, status word 1 bits [14:9]}. When it is clear, key_o is the reserved value 7'h7F.
- R6: ant_o equals bit 19 of status word 0, and more_o equals bit 12 of status word 0.
- R7: len_o is status word 0 bits [11:0], rssi_o is bits [27:20] and rate_o is bits [18:15], with the rate not remapped.
- R8: When frame OK is set, err_o is 0 (none) and phy_o is 0, whatever the other error bits hold.
- R9: A request accepted at one clock edge gives out_valid_o = 1 after that edge. While out_ready_i is low, the response and out_valid_o stay unchanged.
- R10: After reset, out_valid_o is 0 and in_ready_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request valid |
| in_ready_o | output | 1 | Request can be accepted |
| stat0_i | input | 32 | Status word 0 of the descriptor |
| stat1_i | input | 32 | Status word 1 of the descriptor |
| next_done_i | input | 1 | Done bit of the following descriptor |
| hw_ptr_i | input | 32 | Current hardware receive descriptor pointer |
| desc_addr_i | input | 32 | Address of this descriptor |
| out_valid_o | output | 1 | Response valid |
| out_ready_i | input | 1 | Consumer takes the response |
| pend_o | output | 1 | Descriptor not yet usable |
| len_o | output | 12 | Frame data length |
| rssi_o | output | 8 | Signal strength |
| rate_o | output | 4 | Raw rate code |
| ant_o | output | 1 | Antenna |
| more_o | output | 1 | More fragments follow |
| key_o | output | 7 | Key index, or 7'h7F when invalid |
| err_o | output | 3 | Error class: 0 none, 1 CRC, 2 decrypt, 3 FIFO, 4 PHY |
| phy_o | output | 3 | PHY error code |

## Verification
The self-linked-tail test and the error classification both read status word 1 in the same cycle. A descriptor can carry done and several error bits together and still have to come back pending.

The bench provokes this by sending words that set done, a mix of error bits and a key. It pairs them with a pointer equal to the descriptor address and the next descriptor not done, then repeats the same words with either condition removed. The pending copy is judged by all-zero result fields, and the others are judged by the class the priority picks.

Responses are also stalled at irregular intervals, so that the one-cycle latency and the holding of a response are checked under backpressure.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int unsigned ERR_W = 3;
  typedef enum logic [ERR_W-1:0] {
    ERR_NONE    = 3'd0,
    ERR_CRC     = 3'd1,
    ERR_DECRYPT = 3'd2,
    ERR_FIFO    = 3'd3,
    ERR_PHY     = 3'd4
  } err_cls_e;
endpackage

// File: rtl/rxd_gate.sv
module rxd_gate #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DONE_BIT = 0
) (
  input  logic [31:0]       stat1_i,
  input  logic              next_done_i,
  input  logic [ADDR_W-1:0] hw_ptr_i,
  input  logic [ADDR_W-1:0] desc_addr_i,
  output logic              pend_o
);
  logic cur_done;
  logic tail_busy;
  logic unused_s1;

  assign cur_done  = stat1_i[DONE_BIT];
  // engine may still re-enter a self-linked tail
  assign tail_busy = !next_done_i && (hw_ptr_i == desc_addr_i);
  assign pend_o    = !cur_done || tail_busy;
  assign unused_s1 = ^stat1_i;
endmodule

// File: rtl/rxd_err_class.sv
module rxd_err_class
  import rxd_pkg::*;
#(
  parameter int unsigned OK_BIT   = 1,
  parameter int unsigned CRC_BIT  = 2,
  parameter int unsigned DCRC_BIT = 3,
  parameter int unsigned FIFO_BIT = 4,
  parameter int unsigned PHY_LSB  = 5,
  parameter int unsigned PHY_W    = 3
) (
  input  logic [31:0]      stat1_i,
  output err_cls_e         err_o,
  output logic [PHY_W-1:0] phy_o
);
  logic unused_s1;
  assign unused_s1 = ^stat1_i;

  always_comb begin
    err_o = ERR_NONE;
    phy_o = '0;
    if (!stat1_i[OK_BIT]) begin
      if (stat1_i[CRC_BIT])       err_o = ERR_CRC;
      else if (stat1_i[DCRC_BIT]) err_o = ERR_DECRYPT;
      else if (stat1_i[FIFO_BIT]) err_o = ERR_FIFO;
      else begin
        err_o = ERR_PHY;
        phy_o = stat1_i[PHY_LSB +: PHY_W];
      end
    end
  end
endmodule

// File: rtl/rxd_fields.sv
module rxd_fields #(
  parameter int unsigned LEN_W    = 12,
  parameter int unsigned RSSI_W   = 8,
  parameter int unsigned RATE_W   = 4,
  parameter int unsigned KEY_W    = 6,
  parameter int unsigned LEN_LSB  = 0,
  parameter int unsigned MORE_BIT = 12,
  parameter int unsigned RATE_LSB = 15,
  parameter int unsigned ANT_BIT  = 19,
  parameter int unsigned RSSI_LSB = 20,
  parameter int unsigned KV_BIT   = 8,
  parameter int unsigned KEY_LSB  = 9,
  localparam int unsigned OKEY_W  = KEY_W + 1
) (
  input  logic [31:0]       stat0_i,
  input  logic [31:0]       stat1_i,
  output logic [LEN_W-1:0]  len_o,
  output logic [RSSI_W-1:0] rssi_o,
  output logic [RATE_W-1:0] rate_o,
  output logic              ant_o,
  output logic              more_o,
  output logic [OKEY_W-1:0] key_o
);
  localparam logic [OKEY_W-1:0] KEY_NONE = '1;
  logic unused_w;

  assign len_o    = stat0_i[LEN_LSB  +: LEN_W];
  assign rssi_o   = stat0_i[RSSI_LSB +: RSSI_W];
  assign rate_o   = stat0_i[RATE_LSB +: RATE_W];
  assign ant_o    = stat0_i[ANT_BIT];
  assign more_o   = stat0_i[MORE_BIT];
  assign key_o    = stat1_i[KV_BIT] ? {1'b0, stat1_i[KEY_LSB +: KEY_W]} : KEY_NONE;
  assign unused_w = ^{stat0_i, stat1_i};
endmodule

// File: rtl/rx_status_decoder.sv
module rx_status_decoder
  import rxd_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned LEN_W    = 12,
  parameter int unsigned RSSI_W   = 8,
  parameter int unsigned RATE_W   = 4,
  parameter int unsigned KEY_W    = 6,
  parameter int unsigned PHY_W    = 3,
  parameter int unsigned LEN_LSB  = 0,
  parameter int unsigned MORE_BIT = 12,
  parameter int unsigned RATE_LSB = 15,
  parameter int unsigned ANT_BIT  = 19,
  parameter int unsigned RSSI_LSB = 20,
  parameter int unsigned DONE_BIT = 0,
  parameter int unsigned OK_BIT   = 1,
  parameter int unsigned CRC_BIT  = 2,
  parameter int unsigned DCRC_BIT = 3,
  parameter int unsigned FIFO_BIT = 4,
  parameter int unsigned PHY_LSB  = 5,
  parameter int unsigned KV_BIT   = 8,
  parameter int unsigned KEY_LSB  = 9,
  localparam int unsigned OKEY_W  = KEY_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [31:0]       stat0_i,
  input  logic [31:0]       stat1_i,
  input  logic              next_done_i,
  input  logic [ADDR_W-1:0] hw_ptr_i,
  input  logic [ADDR_W-1:0] desc_addr_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              pend_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [RSSI_W-1:0] rssi_o,
  output logic [RATE_W-1:0] rate_o,
  output logic              ant_o,
  output logic              more_o,
  output logic [OKEY_W-1:0] key_o,
  output logic [ERR_W-1:0]  err_o,
  output logic [PHY_W-1:0]  phy_o
);
  typedef struct packed {
    logic              pend;
    logic [LEN_W-1:0]  len;
    logic [RSSI_W-1:0] rssi;
    logic [RATE_W-1:0] rate;
    logic              ant;
    logic              more;
    logic [OKEY_W-1:0] key;
    err_cls_e          err;
    logic [PHY_W-1:0]  phy;
  } result_t;

  logic      gate_pend;
  err_cls_e  cls_err;
  logic [PHY_W-1:0]  cls_phy;
  logic [LEN_W-1:0]  f_len;
  logic [RSSI_W-1:0] f_rssi;
  logic [RATE_W-1:0] f_rate;
  logic              f_ant, f_more;
  logic [OKEY_W-1:0] f_key;
  result_t   nxt_res, res_q;
  logic      vld_q;
  logic      accept;

  rxd_gate #(.ADDR_W(ADDR_W), .DONE_BIT(DONE_BIT)) u_gate (
    .stat1_i    (stat1_i),
    .next_done_i(next_done_i),
    .hw_ptr_i   (hw_ptr_i),
    .desc_addr_i(desc_addr_i),
    .pend_o     (gate_pend)
  );

  rxd_err_class #(
    .OK_BIT(OK_BIT), .CRC_BIT(CRC_BIT), .DCRC_BIT(DCRC_BIT),
    .FIFO_BIT(FIFO_BIT), .PHY_LSB(PHY_LSB), .PHY_W(PHY_W)
  ) u_cls (
    .stat1_i(stat1_i),
    .err_o  (cls_err),
    .phy_o  (cls_phy)
  );

  rxd_fields #(
    .LEN_W(LEN_W), .RSSI_W(RSSI_W), .RATE_W(RATE_W), .KEY_W(KEY_W),
    .LEN_LSB(LEN_LSB), .MORE_BIT(MORE_BIT), .RATE_LSB(RATE_LSB),
    .ANT_BIT(ANT_BIT), .RSSI_LSB(RSSI_LSB), .KV_BIT(KV_BIT), .KEY_LSB(KEY_LSB)
  ) u_fld (
    .stat0_i(stat0_i),
    .stat1_i(stat1_i),
    .len_o  (f_len),
    .rssi_o (f_rssi),
    .rate_o (f_rate),
    .ant_o  (f_ant),
    .more_o (f_more),
    .key_o  (f_key)
  );

  always_comb begin
    nxt_res = '0;
    nxt_res.err = ERR_NONE;
    if (gate_pend) begin
      nxt_res.pend = 1'b1;
    end else begin
      nxt_res.len  = f_len;
      nxt_res.rssi = f_rssi;
      nxt_res.rate = f_rate;
      nxt_res.ant  = f_ant;
      nxt_res.more = f_more;
      nxt_res.key  = f_key;
      nxt_res.err  = cls_err;
      nxt_res.phy  = cls_phy;
    end
  end

  assign in_ready_o = !vld_q || out_ready_i;
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else if (accept) begin
      vld_q <= 1'b1;
      res_q <= nxt_res;
    end else if (out_ready_i) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid_o = vld_q;
  assign pend_o      = res_q.pend;
  assign len_o       = res_q.len;
  assign rssi_o      = res_q.rssi;
  assign rate_o      = res_q.rate;
  assign ant_o       = res_q.ant;
  assign more_o      = res_q.more;
  assign key_o       = res_q.key;
  assign err_o       = res_q.err;
  assign phy_o       = res_q.phy;
endmodule

// File: rtl/rxd_checker.sv
module rxd_checker #(
  parameter int unsigned LEN_W  = 12,
  parameter int unsigned RSSI_W = 8,
  parameter int unsigned RATE_W = 4,
  parameter int unsigned OKEY_W = 7,
  parameter int unsigned PHY_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic              pend_o,
  input logic [LEN_W-1:0]  len_o,
  input logic [RSSI_W-1:0] rssi_o,
  input logic [RATE_W-1:0] rate_o,
  input logic              ant_o,
  input logic              more_o,
  input logic [OKEY_W-1:0] key_o,
  input logic [2:0]        err_o,
  input logic [PHY_W-1:0]  phy_o
);
  AST_PEND_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && pend_o |-> (len_o == '0 && rssi_o == '0 && rate_o == '0 && !ant_o
                               && !more_o && key_o == '0 && err_o == '0 && phy_o == '0)); // R1
  AST_ERR_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> err_o <= 3'd4); // R3
  AST_PHY_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && err_o != 3'd4 |-> phy_o == '0); // R4
  AST_KEY_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && key_o[OKEY_W-1] |-> key_o == '1); // R5
  AST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o); // R9
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable({pend_o, len_o, rssi_o, rate_o,
                                    ant_o, more_o, key_o, err_o, phy_o})); // R9
endmodule

bind rx_status_decoder rxd_checker #(
  .LEN_W(LEN_W), .RSSI_W(RSSI_W), .RATE_W(RATE_W), .OKEY_W(OKEY_W), .PHY_W(PHY_W)
) u_rxd_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
  .out_valid_o(out_valid_o), .out_ready_i(out_ready_i), .pend_o(pend_o), .len_o(len_o),
  .rssi_o(rssi_o), .rate_o(rate_o), .ant_o(ant_o), .more_o(more_o), .key_o(key_o),
  .err_o(err_o), .phy_o(phy_o)
);

// File: tb/tb_rx_status_decoder.sv
`timescale 1ns/1ps
module tb_rx_status_decoder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [31:0] stat0_i = '0, stat1_i = '0, hw_ptr_i = '0, desc_addr_i = '0;
  logic        next_done_i = 1'b0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b1;
  logic        pend_o, ant_o, more_o;
  logic [11:0] len_o;
  logic [7:0]  rssi_o;
  logic [3:0]  rate_o;
  logic [6:0]  key_o;
  logic [2:0]  err_o, phy_o;

  int n_chk = 0, n_fail = 0;
  bit bp = 1'b0;
  bit finished = 1'b0;
  logic [39:0] exp_q[$];
  string       tag_q[$];

  always #10 clk_i = ~clk_i;

  rx_status_decoder dut (.*);

  function automatic logic [39:0] expect_of(logic [31:0] s0, logic [31:0] s1,
                                            logic nd, logic [31:0] ptr, logic [31:0] adr);
    logic [6:0] key;
    logic [2:0] err, phy;
    if (!s1[0] || (!nd && ptr == adr)) return {1'b1, 39'd0};
    key = s1[8] ? {1'b0, s1[14:9]} : 7'h7F;
    err = 3'd0; phy = 3'd0;
    if (!s1[1]) begin
      if (s1[2]) err = 3'd1;
      else if (s1[3]) err = 3'd2;
      else if (s1[4]) err = 3'd3;
      else begin err = 3'd4; phy = s1[7:5]; end
    end
    return {1'b0, s0[11:0], s0[27:20], s0[18:15], s0[19], s0[12], key, err, phy};
  endfunction

  function automatic logic [39:0] actual();
    return {pend_o, len_o, rssi_o, rate_o, ant_o, more_o, key_o, err_o, phy_o};
  endfunction

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input string tag, input logic [31:0] s0, input logic [31:0] s1,
                      input logic nd, input logic [31:0] ptr, input logic [31:0] adr);
    @(negedge clk_i);
    stat0_i = s0; stat1_i = s1; next_done_i = nd; hw_ptr_i = ptr; desc_addr_i = adr;
    in_valid_i = 1'b1;
    exp_q.push_back(expect_of(s0, s1, nd, ptr, adr));
    tag_q.push_back(tag);
    forever begin
      #2;
      if (in_ready_o) break;
      @(negedge clk_i);
    end
    @(posedge clk_i);
    #3 in_valid_i = 1'b0;
  endtask

  // monitor: sets ready at negedge, then compares transfers that happen at next posedge
  initial begin : monitor
    int cyc = 0;
    bit stalled = 1'b0;
    logic [39:0] held = '0;
    forever begin
      @(negedge clk_i);
      cyc++;
      out_ready_i = bp ? ((cyc % 4) != 3 && (cyc % 7) != 2) : 1'b1;
      #1;
      if (rst_ni) begin
        if (stalled) check("R9 hold", {out_valid_o, actual()} [39:0], held);
        stalled = out_valid_o && !out_ready_i;
        held = actual();
        if (stalled) held = {1'b1, actual()} [39:0];
        if (out_valid_o && out_ready_i) begin
          if (exp_q.size() == 0) begin
            check("R9 spurious", 40'd1, 40'd0);
          end else begin
            check(tag_q.pop_front(), actual(), exp_q.pop_front());
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] a = 32'h0000_1000;
    repeat (2) @(negedge clk_i);
    #3;
    check("R10 reset", {39'd0, out_valid_o}, 40'd0);
    check("R10 reset ready", {39'd0, in_ready_o}, 40'd1);
    rst_ni = 1'b1;
    @(negedge clk_i);

    send("R9 latency", 32'h0ABC_8123, 32'h0000_0003, 1'b1, a, a);
    @(negedge clk_i); #3;
    check("R9 latency", {39'd0, out_valid_o}, 40'd1);

    send("R1 not done", 32'h0FFF_FFFF, 32'h0000_7FFE, 1'b1, 32'h0, a);
    send("R2 tail pending", 32'h0123_4567, 32'h0000_13E5, 1'b0, a, a);
    send("R2 ptr moved", 32'h0123_4567, 32'h0000_13E5, 1'b0, a + 32'h10, a);
    send("R2 next done", 32'h0123_4567, 32'h0000_13E5, 1'b1, a, a);
    send("R8 ok masks errors", 32'h0000_0040, 32'h0000_00FF, 1'b1, 32'h0, a);
    send("R3 crc wins", 32'h0000_0001, 32'h0000_001D, 1'b1, 32'h0, a);
    send("R3 decrypt", 32'h0000_0002, 32'h0000_0019, 1'b1, 32'h0, a);
    send("R3 fifo", 32'h0000_0003, 32'h0000_0011, 1'b1, 32'h0, a);
    send("R4 phy code", 32'h0000_0004, 32'h0000_00A1, 1'b1, 32'h0, a);
    send("R4 phy masked by crc", 32'h0000_0005, 32'h0000_00E5, 1'b1, 32'h0, a);
    send("R5 key valid", 32'h0, 32'h0000_7F03, 1'b1, 32'h0, a);
    send("R5 key zero", 32'h0, 32'h0000_0103, 1'b1, 32'h0, a);
    send("R5 key invalid", 32'h0, 32'h0000_7E03, 1'b1, 32'h0, a);
    send("R6 ant only", 32'h0008_0000, 32'h0000_0003, 1'b1, 32'h0, a);
    send("R6 more only", 32'h0000_1000, 32'h0000_0003, 1'b1, 32'h0, a);
    send("R7 max fields", 32'h0FFF_8FFF, 32'h0000_0003, 1'b1, 32'h0, a);
    send("R7 gap bits ignored", 32'hF000_6000, 32'h0000_0003, 1'b1, 32'h0, a);

    bp = 1'b1;
    for (int i = 0; i < 24; i++) begin
      logic [31:0] s0 = 32'h0135_79BD * (i + 3);
      logic [31:0] s1 = (32'h0000_2469 * (i + 1)) | 32'h1;
      send("R2 R3 mixed under stall", s0, s1, i[0], (i % 3 == 0) ? a : a + 4, a);
    end
    bp = 1'b0;
    repeat (8) @(negedge clk_i);
    check("R9 drained", {32'd0, 8'(exp_q.size())}, 40'd0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule